// File: doc/BRIEF.md
# Expired-Timer Flag Scanner

This block keeps one sticky timeout flag for each of 1024 software timers. The flags are held as 32 words of 32 bits. When a timer runs out, the counting logic elsewhere sends a one-cycle expiry pulse with the timer's index. The scanner then raises an interrupt request and presents the index of the lowest-numbered pending timer as a ready value. The interrupt handler therefore never scans bits and needs no separate vector for each timer.

The handler reads the pending index and services that timer. It then writes the same index to the acknowledge port, which clears the flag. A registered two-level search (first across the word-summary bits, then across the bits of the chosen word) presents the next pending timer one cycle later. The handler loops once per expired timer. Any flag word can also be read back directly for debug.

Top module: `expiry_flag_scanner`

## Requirements
- R1: During and right after reset, every flag is clear, and `irq` and `pend_valid` are low.
- R2: A cycle with `exp_valid` high sets the flag addressed by `exp_index`. Bits [9:5] of the index select the word and bits [4:0] select the bit in that word. The flag stays set until it is acknowledged.
- R3: A cycle with `ack_valid` high clears the flag addressed by `ack_index`, using the same word/bit split.
- R4: If an expiry and an acknowledge name the same index in the same cycle, that flag is set after the edge.
- R5: `irq` is the OR of the per-word summary bits. It is high in every cycle in which at least one flag is set, and low once all flags are clear.
- R6: `pend_valid` and `pend_index` are registered. After each clock edge they describe the flags as they stood before that edge. `pend_index` is the lowest pending index: the lowest word first, then the lowest bit within that word.
- R7: `rd_word_data` always shows the current contents of the flag word selected by `rd_word_sel`.
- R8: An expiry and an acknowledge to different indices in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_valid | input | 1 | Expiry pulse |
| exp_index | input | 10 | Index of the expiring timer |
| ack_valid | input | 1 | Acknowledge write strobe |
| ack_index | input | 10 | Index to clear |
| rd_word_sel | input | 5 | Flag word selected for debug read |
| rd_word_data | output | 32 | Contents of the selected flag word |
| irq | output | 1 | Interrupt request, high while any flag is set |
| pend_valid | output | 1 | `pend_index` holds a pending timer |
| pend_index | output | 10 | Lowest pending timer index |

## Verification
Directed steps place lone flags at the two ends of the index range and in the middle of words. Placing a higher index after a lower one shows whether the word-level or the bit-level priority is wrong. Same-index and different-index expiry/acknowledge collisions separate set-wins behaviour from a lost expiry or a lost clear. A handler-style random phase acknowledges the reported index while fresh expiries arrive, and randomly spread indices fill many words. Every cycle of that phase compares the request line, the registered index and a randomly chosen readback word against a bench model. This catches off-by-one-cycle errors and errors in the word/bit split.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
   localparam int DEF_WORDS  = 32;
   localparam int DEF_WORD_W = 32;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tscan_prio.sv
module tscan_prio #(
   parameter int W  = 32,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) idx = i[IW-1:0];
      end
   end
   assign found = |req;
endmodule

// File: rtl/tscan_flag_bank.sv
module tscan_flag_bank #(
   parameter int NWORDS = 32,
   parameter int WORD_W = 32,
   localparam int WSEL_W = $clog2(NWORDS),
   localparam int BIT_W  = $clog2(WORD_W),
   localparam int IDX_W  = WSEL_W + BIT_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           set_vld,
   input  logic [IDX_W-1:0]               set_idx,
   input  logic                           clr_vld,
   input  logic [IDX_W-1:0]               clr_idx,
   output logic [NWORDS-1:0][WORD_W-1:0]  words,
   output logic [NWORDS-1:0]              summary
);
   logic [WSEL_W-1:0] set_w, clr_w;
   logic [BIT_W-1:0]  set_b, clr_b;
   assign set_w = set_idx[IDX_W-1:BIT_W];
   assign set_b = set_idx[BIT_W-1:0];
   assign clr_w = clr_idx[IDX_W-1:BIT_W];
   assign clr_b = clr_idx[BIT_W-1:0];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] set_m, clr_m;
      always_comb begin
         set_m = '0;
         clr_m = '0;
         if (set_vld && set_w == w[WSEL_W-1:0]) set_m[set_b] = 1'b1;
         if (clr_vld && clr_w == w[WSEL_W-1:0]) clr_m[clr_b] = 1'b1;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) words[w] <= '0;
         else        words[w] <= (words[w] & ~clr_m) | set_m;
      end
      assign summary[w] = |words[w];
   end

   // R2 / R4: an expiry always leaves its flag set
   p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_vld |=> words[$past(set_w)][$past(set_b)]);
   // R3: a lone acknowledge clears its flag
   p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && !(set_vld && set_idx == clr_idx)) |=> !words[$past(clr_w)][$past(clr_b)]);
   // R2: without strobes the flags hold
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_vld && !clr_vld) |=> $stable(words));
endmodule

// File: rtl/expiry_flag_scanner.sv
module expiry_flag_scanner #(
   parameter int NWORDS = tscan_pkg::DEF_WORDS,
   parameter int WORD_W = tscan_pkg::DEF_WORD_W,
   localparam int WSEL_W = $clog2(NWORDS),
   localparam int BIT_W  = $clog2(WORD_W),
   localparam int IDX_W  = WSEL_W + BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exp_valid,
   input  logic [IDX_W-1:0]  exp_index,
   input  logic              ack_valid,
   input  logic [IDX_W-1:0]  ack_index,
   input  logic [WSEL_W-1:0] rd_word_sel,
   output logic [WORD_W-1:0] rd_word_data,
   output logic              irq,
   output logic              pend_valid,
   output logic [IDX_W-1:0]  pend_index
);
   if (!tscan_pkg::is_pow2(NWORDS) || !tscan_pkg::is_pow2(WORD_W)) begin : g_bad_cfg
      $error("NWORDS and WORD_W must be powers of two, at least 2");
   end

   logic [NWORDS-1:0][WORD_W-1:0] words;
   logic [NWORDS-1:0]             summary;
   logic                          w_found, b_found;
   logic [WSEL_W-1:0]             w_sel;
   logic [BIT_W-1:0]              b_sel;

   tscan_flag_bank #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_vld(exp_valid), .set_idx(exp_index),
      .clr_vld(ack_valid), .clr_idx(ack_index),
      .words(words), .summary(summary));

   tscan_prio #(.W(NWORDS)) u_word_pick (.req(summary), .found(w_found), .idx(w_sel));
   tscan_prio #(.W(WORD_W)) u_bit_pick  (.req(words[w_sel]), .found(b_found), .idx(b_sel));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_index <= '0;
      end else begin
         pend_valid <= w_found && b_found;
         pend_index <= {w_sel, b_sel};
      end
   end

   assign irq          = |summary;
   assign rd_word_data = words[rd_word_sel];

   // R6: the registered valid trails the request line by one cycle
   p_valid_trails_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (pend_valid == $past(irq)));
   // R6: a reported index was pending in the word the summary marked
   p_index_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && w_found) |=> pend_index[IDX_W-1:BIT_W] == $past(w_sel));
   // R5: request is high whenever the debug port shows a non-zero word
   p_irq_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word_data != '0) |-> irq);
endmodule

// File: tb/expiry_flag_scanner_tb.sv
module expiry_flag_scanner_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, exp_valid, ack_valid, irq, pend_valid;
   logic [9:0] exp_index, ack_index, pend_index;
   logic [4:0] rd_word_sel;
   logic [31:0] rd_word_data;

   expiry_flag_scanner u_dut (.*);

   int checks = 0, errors = 0;
   logic [1023:0] model, prev_model;

   function automatic logic [10:0] lowest(input logic [1023:0] m);
      for (int i = 0; i < 1024; i++) if (m[i]) return {1'b1, i[9:0]};
      return 11'd0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One clock step; the model follows R2/R3/R4/R8, outputs checked per R5/R6/R7
   task automatic step(input logic ev, input logic [9:0] ei,
                       input logic av, input logic [9:0] ai, input logic [4:0] rs);
      exp_valid = ev; exp_index = ei; ack_valid = av; ack_index = ai; rd_word_sel = rs;
      prev_model = model;
      if (av) model[ai] = 1'b0;
      if (ev) model[ei] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exp_valid = 1'b0; ack_valid = 1'b0;
      chk("R5 irq", {31'd0, irq}, {31'd0, |model});
      chk("R6 pend", {21'd0, pend_valid, pend_index}, {21'd0, lowest(prev_model)});
      chk("R7 readback", rd_word_data, model[rs*32 +: 32]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic [10:0] lw;
      seed = $urandom(32'd2025);
      rst_n = 1'b0; exp_valid = 1'b0; ack_valid = 1'b0;
      exp_index = '0; ack_index = '0; rd_word_sel = '0;
      model = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 valid", {31'd0, pend_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 word0", rd_word_data, 32'd0);

      // R2: index 37 -> word 1 bit 5
      step(1'b1, 10'd37, 1'b0, 10'd0, 5'd1);
      chk("R2 set 37", rd_word_data, 32'h20);
      step(1'b1, 10'd1023, 1'b0, 10'd0, 5'd31);
      chk("R6 lower wins", {22'd0, pend_index}, 32'd37);
      step(1'b1, 10'd3, 1'b0, 10'd0, 5'd0);
      step(1'b0, 10'd0, 1'b0, 10'd0, 5'd0);
      chk("R6 bit pick", {22'd0, pend_index}, 32'd3);
      // R4: same-index collision keeps the flag
      step(1'b1, 10'd3, 1'b1, 10'd3, 5'd0);
      chk("R4 collide", rd_word_data, 32'h8);
      // R3: lone acknowledge clears
      step(1'b0, 10'd0, 1'b1, 10'd3, 5'd0);
      chk("R3 clear", rd_word_data, 32'h0);
      // R8: different indices, same cycle
      step(1'b1, 10'd600, 1'b1, 10'd37, 5'd18);
      chk("R8 set side", rd_word_data, 32'h1 << (600 % 32));
      step(1'b0, 10'd0, 1'b0, 10'd0, 5'd1);
      chk("R8 clear side", rd_word_data, 32'h0);
      // drain: R5 irq falls when all clear
      step(1'b0, 10'd0, 1'b1, 10'd600, 5'd0);
      step(1'b0, 10'd0, 1'b1, 10'd1023, 5'd0);
      chk("R5 irq low", {31'd0, irq}, 32'd0);
      step(1'b0, 10'd0, 1'b0, 10'd0, 5'd0);
      chk("R6 valid low", {31'd0, pend_valid}, 32'd0);

      // random handler-style phase
      for (int n = 0; n < 4000; n++) begin
         logic ev, av;
         logic [9:0] ei, ai;
         ev = ($urandom % 3) != 0;
         ei = ($urandom % 4 == 0) ? 10'($urandom % 8) : 10'($urandom);
         lw = lowest(model);
         av = ($urandom % 2) == 1;
         ai = ($urandom % 3 == 0) ? 10'($urandom) : lw[9:0];
         if ($urandom % 10 == 0) ai = ei;
         step(ev, ei, av, ai, 5'($urandom));
      end
      // final drain
      for (int n = 0; n < 1100 && |model; n++) begin
         lw = lowest(model);
         step(1'b0, 10'd0, 1'b1, lw[9:0], 5'($urandom));
      end
      chk("R5 drained", {31'd0, irq}, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule